// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Boundary Duty Updates

The block produces four independent pulse-width modulated outputs from one input clock. A small word-addressed register port sets up each channel. Each channel has a mode word, which selects a power-of-two clock divider and the output polarity. It also has a period value, a value that sets the inactive part of each period, and a buffer for changing that value while the channel runs. One free-running divider is shared by all channels, and each channel picks one of its tick rates.

Every period starts at the inactive level. The output turns active once the channel counter reaches the stored inactive count. A new inactive count written to the buffer is held back until the current period ends. At that wrap the buffer is copied into the working value and the channel's interrupt flag is set. The flags are read together and cleared by that read. Channels are started and stopped through two write-one-per-channel registers. A stop request takes effect only when the current period completes, and the channel's status bit stays at 1 until then.

Top module: `pwm_quad_buf`

## Requirements
- R1: After reset every channel is stopped, all outputs are 0, the status and interrupt registers read 0, `irq` is 0 and every channel register reads 0.
- R2: Writing 1 to bit c of the start register (address 0) starts a stopped channel c with its counter at 0. With divider setting 0 the counter advances every clock from 0 to period-1 and then wraps. The output is active while counter >= the inactive count, so each period begins inactive.
- R3: An inactive count of 0 gives an output that is active on every cycle. Any inactive count >= the period gives an output that is never active.
- R4: Mode bits [2:0] select the divider p. The counter advances once every 2^p clocks, so one period lasts period*2^p clocks. Values above 5 are stored and read back as 5.
- R5: Mode bit 3 inverts the output (0 = active high). A stopped channel drives the inactive level, which is the value of bit 3.
- R6: Writes to a channel's period or inactive-count register are ignored while the channel runs: readback and waveform are unchanged. While the channel is stopped such writes are stored.
- R7: A value written to a channel's update buffer (channel offset 3) leaves the working inactive count unchanged until the next wrap. At that wrap the working count takes the buffered value.
- R8: The wrap that applies a buffered value sets bit c of the interrupt register (address 3). `irq` is the OR of that register. A read of address 3 with `rdEn` high returns the bits and clears them.
- R9: Writing 1 to bit c of the stop register (address 1) stops a running channel at the first wrap after the write edge. Until then the status bit (address 2, bit c) stays 1 and the output keeps modulating. A stop write on the very edge of a wrap waits for the following wrap.
- R10: A start write to a running channel does not restart its counter, and it cancels a pending stop.
- R11: Channel c's registers sit at 16+4c plus an offset: 0 mode, 1 period, 2 inactive count, 3 update buffer. Reads return the stored values. Status reads 1 for every running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Read strobe; clears the interrupt register when addressing it |
| addr | input | 6 | Register word address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| pwmOut | output | 4 | Channel outputs |
| irq | output | 1 | OR of the pending update flags |

## Verification
A counter that is off by one, or that wraps at the wrong value, moves the active edge of the waveform. This shows at `pwmOut` within the first period after a start, because the bench compares every cycle against counter = cycles-since-start modulo period. A buffer or pending-stop flag in the wrong state shows as the duty changing, or the status bit dropping, one period early or late. It can also show as a missing or extra interrupt bit on the first wrap after the write. A divider tap chosen wrongly changes the measured distance between rising edges, which is a multiple of the period.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  // global register addresses
  localparam int ADDR_ENA  = 0;
  localparam int ADDR_DIS  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_IRQ  = 3;
  // per-channel window
  localparam int CH_BASE   = 16;
  localparam int CH_STRIDE = 4;

  // strobes from control to one channel datapath
  typedef struct packed {
    logic start;
    logic run;
    logic wrMode;
    logic wrPeriod;
    logic wrDuty;
    logic wrUpd;
  } chanCmd_t;
endpackage

// File: rtl/pwmq_prescale.sv
module pwmq_prescale #(
  parameter int PRES_MAX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PRES_MAX:0] tickVec
);
  localparam int DIV_W = (PRES_MAX < 1) ? 1 : PRES_MAX;

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // tap p fires once every 2^p clocks
  generate
    for (genvar p = 0; p <= PRES_MAX; p++) begin : g_tap
      if (p == 0) begin : g_full
        assign tickVec[p] = 1'b1;
      end else begin : g_div
        assign tickVec[p] = &divCnt[p-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
  import pwmq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRES_W   = 3,
  parameter int PRES_MAX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCmd_t          cmd,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [PRES_MAX:0] tickVec,
  output logic              pwmOut,
  output logic              wrapEv,
  output logic              applied,
  output logic [CNT_W-1:0]  modeQ,
  output logic [CNT_W-1:0]  periodQ,
  output logic [CNT_W-1:0]  dutyQ,
  output logic [CNT_W-1:0]  updQ
);
  localparam int POL_BIT = PRES_W;
  localparam logic [PRES_W-1:0] PRES_CAP = PRES_W'(PRES_MAX);

  logic [PRES_W-1:0] presQ, presIn;
  logic              polQ;
  logic [CNT_W-1:0]  cnt, periodR, dutyR, updBuf;
  logic              updPend;
  logic              tick, stepEv, atEnd;

  assign presIn  = (wrData[PRES_W-1:0] > PRES_CAP) ? PRES_CAP : wrData[PRES_W-1:0];
  assign tick    = tickVec[presQ];
  assign atEnd   = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, periodR};
  assign stepEv  = cmd.run & tick;
  assign wrapEv  = stepEv & atEnd;
  assign applied = wrapEv & updPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presQ <= '0;
      polQ  <= 1'b0;
    end else if (cmd.wrMode) begin
      presQ <= presIn;
      polQ  <= wrData[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (cmd.start)  cnt <= '0;
    else if (stepEv)     cnt <= atEnd ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             periodR <= '0;
    else if (cmd.wrPeriod) periodR <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dutyR <= '0;
    else if (cmd.wrDuty) dutyR <= wrData;
    else if (applied)    dutyR <= updBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updBuf  <= '0;
      updPend <= 1'b0;
    end else if (cmd.wrUpd) begin
      updBuf  <= wrData;
      updPend <= 1'b1;
    end else if (applied) begin
      updPend <= 1'b0;
    end
  end

  assign pwmOut  = cmd.run ? ((cnt >= dutyR) ^ polQ) : polQ;
  assign modeQ   = CNT_W'({polQ, presQ});
  assign periodQ = periodR;
  assign dutyQ   = dutyR;
  assign updQ    = updBuf;

  // R2: counter stays inside the period while running
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && periodR != '0) |-> (cnt < periodR));

  // R6: period is frozen while the channel keeps running
  a_r6_period_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && $past(cmd.run)) |-> $stable(periodR));

  // R7: working inactive count changes only at an applying wrap while running
  a_r7_duty_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && $past(cmd.run) && !$past(applied)) |-> $stable(dutyR));
endmodule

// File: rtl/pwmq_ctrl.sv
module pwmq_ctrl
  import pwmq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NCH-1:0]             wrBits,
  input  logic [NCH-1:0]             wrapEv,
  input  logic [NCH-1:0]             applied,
  input  logic [NCH-1:0][CNT_W-1:0]  modeQ,
  input  logic [NCH-1:0][CNT_W-1:0]  periodQ,
  input  logic [NCH-1:0][CNT_W-1:0]  dutyQ,
  input  logic [NCH-1:0][CNT_W-1:0]  updQ,
  output chanCmd_t [NCH-1:0]         cmdVec,
  output logic [CNT_W-1:0]           rdData,
  output logic                       irq
);
  logic [NCH-1:0]    running, disPend, irqStat;
  logic [NCH-1:0]    enaBit, disBit, sel;
  logic [ADDR_W-1:0] chRel;
  logic [1:0]        regOff;
  logic              chHit, clrIrq, hitEna, hitDis;

  assign hitEna = wrEn && (addr == ADDR_W'(ADDR_ENA));
  assign hitDis = wrEn && (addr == ADDR_W'(ADDR_DIS));
  assign enaBit = {NCH{hitEna}} & wrBits;
  assign disBit = {NCH{hitDis}} & wrBits;
  assign clrIrq = rdEn && (addr == ADDR_W'(ADDR_IRQ));
  assign chRel  = addr - ADDR_W'(CH_BASE);
  assign regOff = chRel[1:0];
  assign chHit  = (addr >= ADDR_W'(CH_BASE)) && (chRel < ADDR_W'(CH_STRIDE*NCH));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sel[c]             = chHit && (chRel[ADDR_W-1:2] == (ADDR_W-2)'(c));
      cmdVec[c].start    = enaBit[c] && !running[c];
      cmdVec[c].run      = running[c];
      cmdVec[c].wrMode   = wrEn && sel[c] && (regOff == 2'd0);
      cmdVec[c].wrPeriod = wrEn && sel[c] && (regOff == 2'd1) && !running[c];
      cmdVec[c].wrDuty   = wrEn && sel[c] && (regOff == 2'd2) && !running[c];
      cmdVec[c].wrUpd    = wrEn && sel[c] && (regOff == 2'd3);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= '0;
      disPend <= '0;
      irqStat <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (enaBit[c]) begin
          running[c] <= 1'b1;
          disPend[c] <= 1'b0;
        end else begin
          if (wrapEv[c] && disPend[c])
            running[c] <= 1'b0;
          if (disBit[c] && running[c] && !(wrapEv[c] && disPend[c]))
            disPend[c] <= 1'b1;
          else if (wrapEv[c])
            disPend[c] <= 1'b0;
        end
      end
      irqStat <= (irqStat & ~{NCH{clrIrq}}) | applied;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_STAT))     rdData = CNT_W'(running);
    else if (addr == ADDR_W'(ADDR_IRQ)) rdData = CNT_W'(irqStat);
    for (int c = 0; c < NCH; c++) begin
      if (sel[c]) begin
        case (regOff)
          2'd0:    rdData = modeQ[c];
          2'd1:    rdData = periodQ[c];
          2'd2:    rdData = dutyQ[c];
          default: rdData = updQ[c];
        endcase
      end
    end
  end

  assign irq = |irqStat;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R9: a channel only stops on its own wrap
      a_r9_stop_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
        $fell(running[c]) |-> $past(wrapEv[c]));
      // R8: a flag is raised only by an applying wrap
      a_r8_flag_from_apply: assert property (@(posedge clk) disable iff (!rstN)
        $rose(irqStat[c]) |-> $past(applied[c]));
      // R2: a channel starts only through the start register
      a_r2_start_by_write: assert property (@(posedge clk) disable iff (!rstN)
        $rose(running[c]) |-> $past(wrEn && addr == ADDR_W'(ADDR_ENA)));
    end
  endgenerate
endmodule

// File: rtl/pwm_quad_buf.sv
module pwm_quad_buf
  import pwmq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CNT_W    = 8,
  parameter int PRES_W   = 3,
  parameter int PRES_MAX = 5,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    pwmOut,
  output logic              irq
);
  logic [PRES_MAX:0]            tickVec;
  chanCmd_t [NCH-1:0]           cmdVec;
  logic [NCH-1:0]               wrapEv, applied;
  logic [NCH-1:0][CNT_W-1:0]    modeQ, periodQ, dutyQ, updQ;

  pwmq_prescale #(.PRES_MAX(PRES_MAX)) u_pres (
    .clk(clk), .rstN(rstN), .tickVec(tickVec)
  );

  pwmq_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrBits(wrData[NCH-1:0]), .wrapEv(wrapEv), .applied(applied),
    .modeQ(modeQ), .periodQ(periodQ), .dutyQ(dutyQ), .updQ(updQ),
    .cmdVec(cmdVec), .rdData(rdData), .irq(irq)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwmq_chan #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_chan (
        .clk(clk), .rstN(rstN), .cmd(cmdVec[c]), .wrData(wrData),
        .tickVec(tickVec), .pwmOut(pwmOut[c]), .wrapEv(wrapEv[c]),
        .applied(applied[c]), .modeQ(modeQ[c]), .periodQ(periodQ[c]),
        .dutyQ(dutyQ[c]), .updQ(updQ[c])
      );
    end
  endgenerate
endmodule

// File: tb/pwm_quad_buf_tb.sv
module pwm_quad_buf_tb;
  localparam int A_ENA = 0, A_DIS = 1, A_STAT = 2, A_IRQ = 3;

  logic       clk = 1'b0;
  logic       rstN, wrEn, rdEn;
  logic [5:0] addr;
  logic [7:0] wrData, rdData;
  logic [3:0] pwmOut;
  logic       irq;

  int total = 0, bad = 0, cyc = 0, base = 0;
  bit finished = 0;

  pwm_quad_buf u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int chA(input int c, input int off);
    return 16 + 4*c + off;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 6'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    addr = 6'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic rdClr(output int v);
    @(negedge clk);
    addr = 6'(A_IRQ); rdEn = 1'b1;
    #1;
    v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitStop(input int mask);
    int v;
    for (int i = 0; i < 400; i++) begin
      peek(A_STAT, v);
      if ((v & mask) == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic drive(input int a, input int d);
    addr = 6'(a); wrData = 8'(d); wrEn = 1'b1;
  endtask

  // R9: stop write on cycle dk of a 5-cycle period, inactive count 2, channel 1
  task automatic disTest(input int dk);
    int v, stopK, k;
    stopK = (dk/5 + 1) * 5 + ((dk % 5 == 4) ? 5 : 0);
    wr(chA(1,1), 5); wr(chA(1,2), 2); wr(A_ENA, 2);
    base = cyc;
    for (int i = 0; i <= stopK + 3; i++) begin
      wrEn = 1'b0;
      k = cyc - base;
      peek(A_STAT, v);
      chk("R9 status during stop", (v >> 1) & 1, (k < stopK) ? 1 : 0);
      chk("R9 output during stop", int'(pwmOut[1]), (k < stopK) ? (((k % 5) >= 2) ? 1 : 0) : 0);
      if (k == dk) drive(A_DIS, 2);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic measure(output int len);
    int r1, r2;
    bit prev;
    r1 = -1; r2 = -1;
    prev = pwmOut[0];
    for (int i = 0; i < 1000 && r2 < 0; i++) begin
      @(negedge clk);
      if (!prev && pwmOut[0]) begin
        if (r1 < 0) r1 = cyc; else r2 = cyc;
      end
      prev = pwmOut[0];
    end
    len = (r2 < 0) ? -1 : r2 - r1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    int v, k, len, expP;
    wrEn = 0; rdEn = 0; addr = 0; wrData = 0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    chk("R1 outputs", int'(pwmOut), 0);
    chk("R1 irq", int'(irq), 0);
    peek(A_STAT, v); chk("R1 status", v, 0);
    peek(A_IRQ, v);  chk("R1 flags", v, 0);
    peek(chA(0,0), v); chk("R1 mode", v, 0);
    peek(chA(2,1), v); chk("R1 period", v, 0);

    // R2 R3 R11: sweep of period and inactive count, all four channels at once
    for (int p = 1; p <= 6; p++) begin
      for (int g = 0; g <= p + 1; g += 4) begin
        for (int c = 0; c < 4; c++) begin
          wr(chA(c,1), p); wr(chA(c,2), g + c);
        end
        for (int c = 0; c < 4; c++) begin
          peek(chA(c,2), v); chk("R11 inactive count readback", v, g + c);
          peek(chA(c,1), v); chk("R11 period readback", v, p);
        end
        wr(A_ENA, 15);
        base = cyc;
        peek(A_STAT, v); chk("R11 status all running", v, 15);
        for (int i = 0; i < 2*p + 2; i++) begin
          k = cyc - base;
          for (int c = 0; c < 4; c++) begin
            if (g + c == 0 || g + c >= p)
              chk("R3 full or empty duty", int'(pwmOut[c]), ((k % p) >= g + c) ? 1 : 0);
            else
              chk("R2 waveform", int'(pwmOut[c]), ((k % p) >= g + c) ? 1 : 0);
          end
          @(negedge clk);
        end
        wr(A_DIS, 15);
        waitStop(15);
        peek(A_STAT, v); chk("R9 all stopped", v, 0);
        chk("R5 stopped outputs inactive", int'(pwmOut), 0);
      end
    end

    // R9: stop mid-period and on the wrap edge
    disTest(2);
    waitStop(2);
    disTest(4);
    waitStop(2);

    // R10: start during a pending stop cancels it without restarting
    wr(chA(2,1), 6); wr(chA(2,2), 3); wr(A_ENA, 4);
    base = cyc;
    for (int i = 0; i < 14; i++) begin
      wrEn = 1'b0;
      k = cyc - base;
      peek(A_STAT, v);
      chk("R10 still running", (v >> 2) & 1, 1);
      chk("R10 waveform continuous", int'(pwmOut[2]), ((k % 6) >= 3) ? 1 : 0);
      if (k == 1) drive(A_DIS, 4);
      if (k == 3) drive(A_ENA, 4);
      @(negedge clk);
    end
    wrEn = 1'b0;
    wr(A_DIS, 4);
    waitStop(4);

    // R7 R8: buffered update applies at the wrap and raises the flag
    wr(chA(0,1), 4); wr(chA(0,2), 3); wr(A_ENA, 1);
    base = cyc;
    for (int i = 0; i < 10; i++) begin
      wrEn = 1'b0;
      k = cyc - base;
      if (k == 2) begin
        peek(chA(0,2), v); chk("R7 working count held before wrap", v, 3);
      end
      chk("R7 waveform around update", int'(pwmOut[0]), ((k % 4) >= ((k < 4) ? 3 : 1)) ? 1 : 0);
      chk("R8 irq timing", int'(irq), (k >= 4) ? 1 : 0);
      if (k == 1) drive(chA(0,3), 1);
      @(negedge clk);
    end
    wrEn = 1'b0;
    peek(A_IRQ, v); chk("R8 flag visible", v, 1);
    rdClr(v);       chk("R8 read returns flag", v, 1);
    peek(A_IRQ, v); chk("R8 flag cleared", v, 0);
    chk("R8 irq cleared", int'(irq), 0);
    peek(chA(0,2), v); chk("R7 working count updated", v, 1);
    wr(A_DIS, 1);
    waitStop(1);

    // R8: two channels flag together
    wr(chA(1,1), 2); wr(chA(1,2), 0); wr(chA(3,1), 2); wr(chA(3,2), 0);
    wr(A_ENA, 10);
    wr(chA(1,3), 1); wr(chA(3,3), 2);
    repeat (6) @(negedge clk);
    rdClr(v); chk("R8 two flags", v, 10);
    wr(A_DIS, 10);
    waitStop(10);

    // R6: period and inactive count writes ignored while running
    wr(chA(0,1), 4); wr(chA(0,2), 1); wr(A_ENA, 1);
    base = cyc;
    wr(chA(0,1), 7); wr(chA(0,2), 2);
    peek(chA(0,1), v); chk("R6 period ignored", v, 4);
    peek(chA(0,2), v); chk("R6 inactive count ignored", v, 1);
    for (int i = 0; i < 8; i++) begin
      k = cyc - base;
      chk("R6 waveform unchanged", int'(pwmOut[0]), ((k % 4) >= 1) ? 1 : 0);
      @(negedge clk);
    end
    wr(A_DIS, 1);
    waitStop(1);
    wr(chA(0,1), 7);
    peek(chA(0,1), v); chk("R6 period accepted when stopped", v, 7);

    // R5: polarity
    wr(chA(3,0), 8);
    chk("R5 stopped inverted level", int'(pwmOut[3]), 1);
    peek(chA(3,0), v); chk("R5 mode readback", v, 8);
    wr(chA(3,1), 4); wr(chA(3,2), 1); wr(A_ENA, 8);
    base = cyc;
    for (int i = 0; i < 8; i++) begin
      k = cyc - base;
      chk("R5 inverted waveform", int'(pwmOut[3]), ((k % 4) >= 1) ? 0 : 1);
      @(negedge clk);
    end
    wr(A_DIS, 8);
    waitStop(8);
    chk("R5 stopped after inverted run", int'(pwmOut[3]), 1);
    wr(chA(3,0), 0);
    chk("R5 normal stopped level", int'(pwmOut[3]), 0);

    // R4: divider sweep, period 3, inactive count 1
    wr(chA(0,1), 3); wr(chA(0,2), 1);
    for (int p = 0; p <= 7; p++) begin
      if (p == 6) continue;
      wr(chA(0,0), p);
      if (p == 7) begin
        peek(chA(0,0), v); chk("R4 divider clamp readback", v, 5);
      end
      wr(A_ENA, 1);
      measure(len);
      expP = 3 << ((p > 5) ? 5 : p);
      chk("R4 period length", len, expP);
      wr(A_DIS, 1);
      waitStop(1);
    end
    peek(A_STAT, v); chk("R9 final stopped", v, 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule